// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one successive-approximation conversion of a sampled analog input and hands back a signed or unsigned result. A one-cycle acquisition strobe puts the track/hold into tracking. The bus-stop strobe that follows switches it to hold, and the bit search starts in the same step.

The search runs on an internal conversion clock. That clock is a clock-enable tick divided by a parameter. On each divided step the block commits the bit under trial from the comparator answer and then raises the next lower bit. The trial code drives the DAC.

When the last bit is decided, the result register loads in one of two codings:
- straight binary for a unipolar input;
- two's complement for a bipolar input, which is the same code with its top bit flipped.

An abort input drops the conversion in flight. The previous result stays readable at all times, including during a conversion.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy_o=0, eoc_o=0, hold_o=1 (holding), dac_code_o=0 and result_o=0.
- R2: acq_start_i while idle puts the block in tracking (hold_o=0) from the next cycle. stop_i while tracking sets hold_o=1, busy_o=1 and dac_code_o=0x800 on the next cycle.
- R3: Bits are decided MSB first, one per TICK_DIV tick_i pulses counted during the conversion. A bit under trial is kept when cmp_i=1 (input at or above the trial code) and cleared otherwise, and the next lower bit is set to 1 in the same step.
- R4: A conversion ends on the edge that takes the WIDTH*TICK_DIV-th tick. On that edge busy_o falls and eoc_o goes high for exactly one cycle.
- R5: With bip_i=0 sampled with stop_i, result_o is the search code as straight binary.
- R6: With bip_i=1 sampled with stop_i, result_o is the search code with bit WIDTH-1 inverted, so that the offset code 0x800 reads as 0 in two's complement.
- R7: abort_i during tracking or conversion returns the block to idle on the next cycle with hold_o=1. No eoc_o pulse follows and result_o is unchanged.
- R8: result_o changes only on the cycle eoc_o is raised, and keeps the previous result while a conversion runs.
- R9: stop_i while idle starts nothing. acq_start_i during a conversion has no effect on hold_o or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acq_start_i | input | 1 | Acquisition start strobe |
| stop_i | input | 1 | Bus-stop strobe; ends tracking and starts the conversion |
| abort_i | input | 1 | Shutdown abort of tracking or conversion |
| bip_i | input | 1 | Polarity: 1 bipolar, 0 unipolar; sampled with stop_i |
| tick_i | input | 1 | Clock-enable tick for the conversion clock divider |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_code_o | output | WIDTH | Trial DAC code |
| hold_o | output | 1 | Track/hold control: 0 tracking, 1 holding |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | WIDTH | Last completed result |

## Verification
The bench builds the block with WIDTH=12 and TICK_DIV=3, which is the full result width with a divider that is not a power of two. Three ticks per bit let a directed run with a steady tick check the trial code after every bit decision. The same setting lets a random tick pattern check that the conversion ends on exactly the thirty-sixth counted tick. A comparator model over levels 0, 2047, 2048 and 4095 covers both codings at the edge where the polarity flips.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TRACK, ST_CONV} sar_state_e;
endpackage

// File: rtl/sar_tick_div.sv
module sar_tick_div #(
  parameter int TICK_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic step_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign step_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_bit_ctrl.sv
module sar_bit_ctrl #(
  parameter int WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             clear_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] next_o,
  output logic             last_o
);
  localparam int IW = $clog2(WIDTH);
  localparam logic [IW-1:0] TOP = IW'(WIDTH - 1);

  logic [WIDTH-1:0] trial_q;
  logic [IW-1:0]    idx_q;
  logic [IW-1:0]    idx_lo;

  assign idx_lo = idx_q - 1'b1;
  assign last_o = (idx_q == '0);

  // decide current bit, raise the next lower one
  always_comb begin
    next_o = trial_q;
    next_o[idx_q] = cmp_i;
    if (!last_o) next_o[idx_lo] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q <= '0;
      idx_q   <= '0;
    end else if (clear_i) begin
      trial_q <= '0;
      idx_q   <= '0;
    end else if (load_i) begin
      trial_q <= {1'b1, {(WIDTH-1){1'b0}}};
      idx_q   <= TOP;
    end else if (step_i) begin
      trial_q <= next_o;
      idx_q   <= idx_lo;
    end
  end

  assign trial_o = trial_q;

  AST_INDEX_WALKS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !load_i && !last_o) |=> (idx_q == $past(idx_lo))); // R3
endmodule

// File: rtl/sar_coder.sv
module sar_coder #(
  parameter int WIDTH = 12
) (
  input  logic             bip_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] res_o
);
  // offset binary -> two's complement by flipping the sign bit
  assign res_o = {code_i[WIDTH-1] ^ bip_i, code_i[WIDTH-2:0]};
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH    = 12,
  parameter int TICK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acq_start_i,
  input  logic             stop_i,
  input  logic             abort_i,
  input  logic             bip_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             hold_o,
  output logic             busy_o,
  output logic             eoc_o,
  output logic [WIDTH-1:0] result_o
);
  import sar_pkg::*;

  localparam logic [WIDTH-1:0] MSB_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       st_q;
  logic             bip_q, eoc_q;
  logic [WIDTH-1:0] res_q, next_w, coded_w;
  logic             step_w, last_w, in_conv, load_w, done_w, clear_w;

  assign in_conv = (st_q == ST_CONV);
  assign load_w  = (st_q == ST_TRACK) && stop_i && !abort_i;
  assign done_w  = in_conv && !abort_i && step_w && last_w;
  assign clear_w = in_conv && (abort_i || (step_w && last_w));

  sar_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(in_conv),
    .tick_i(tick_i), .step_o(step_w)
  );

  sar_bit_ctrl #(.WIDTH(WIDTH)) u_bits (
    .clk_i  (clk_i), .rst_ni(rst_ni), .load_i(load_w),
    .step_i (step_w && in_conv && !abort_i), .clear_i(clear_w),
    .cmp_i  (cmp_i), .trial_o(dac_code_o), .next_o(next_w), .last_o(last_w)
  );

  sar_coder #(.WIDTH(WIDTH)) u_coder (
    .bip_i(bip_q), .code_i(next_w), .res_o(coded_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      bip_q <= 1'b0;
      res_q <= '0;
      eoc_q <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      unique case (st_q)
        ST_IDLE:  if (acq_start_i) st_q <= ST_TRACK;
        ST_TRACK: begin
          if (abort_i) st_q <= ST_IDLE;
          else if (stop_i) begin
            st_q  <= ST_CONV;
            bip_q <= bip_i;
          end
        end
        ST_CONV: begin
          if (abort_i) st_q <= ST_IDLE;
          else if (done_w) begin
            st_q  <= ST_IDLE;
            res_q <= coded_w;
            eoc_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign hold_o   = (st_q != ST_TRACK);
  assign busy_o   = in_conv;
  assign eoc_o    = eoc_q;
  assign result_o = res_q;

  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> hold_o); // R2
  AST_START_AT_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (dac_code_o == MSB_CODE)); // R3
  AST_EOC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> (!busy_o && $past(busy_o))); // R4
  AST_EOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o); // R4
  AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o) |=> (!busy_o && !eoc_o)); // R7
  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_w |=> $stable(result_o)); // R8
endmodule

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;
  localparam int W = 12;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic acq = 1'b0, stop = 1'b0, abort = 1'b0, bip = 1'b0, tick = 1'b0, cmp;
  logic [W-1:0] dac, res;
  logic hold, busy, eoc;

  int errs = 0, checks = 0, tcnt = 0, ecnt = 0, cyc = 0;
  int level = 0, prev = 0, tick_mode = 0;

  always #2.5 clk = ~clk;

  sar_seq #(.WIDTH(W), .TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .acq_start_i(acq), .stop_i(stop),
    .abort_i(abort), .bip_i(bip), .tick_i(tick), .cmp_i(cmp),
    .dac_code_o(dac), .hold_o(hold), .busy_o(busy), .eoc_o(eoc), .result_o(res)
  );

  assign cmp = (level >= int'(dac));

  always @(negedge clk)
    tick <= (tick_mode == 2) ? 1'b1 : (tick_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busy && tick) tcnt <= tcnt + 1;
    if (eoc) ecnt <= ecnt + 1;
  end

  always @(posedge clk)
    if (cyc > 150000) begin
      errs = errs + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_res(input int lv, input bit b);
    return b ? ((lv - 2048) & 4095) : lv;
  endfunction

  function automatic int exp_trial(input int lv, input int k);
    return ((lv >> (W - k)) << (W - k)) | (1 << (W - k - 1));
  endfunction

  // mode 0: directed steady tick, per-bit checks; 1: random ticks; poke: acq during busy
  task automatic run_conv(input int lv, input bit b, input int mode, input bit poke);
    int t0, n;
    level = lv;
    tick_mode = (mode == 0) ? 2 : 0;
    @(negedge clk) acq = 1'b1;
    @(negedge clk) acq = 1'b0;
    chk(hold == 1'b0, "R2 tracking", int'(hold), 0);
    repeat (2) @(negedge clk);
    stop = 1'b1; bip = b;
    @(negedge clk) stop = 1'b0;
    t0 = tcnt;
    chk(busy && hold, "R2 hold+busy", int'({busy, hold}), 3);
    chk(int'(dac) == 2048, "R3 first trial", int'(dac), 2048);
    if (mode == 0) begin
      for (int k = 1; k < W; k++) begin
        repeat (DIV) @(negedge clk);
        chk(int'(dac) == exp_trial(lv, k), "R3 trial step", int'(dac), exp_trial(lv, k));
      end
      repeat (DIV) @(negedge clk);
    end else begin
      tick_mode = 1;
      n = 0;
      while (!eoc && n < 2000) begin
        @(negedge clk);
        n++;
        if (n == 5 && busy) chk(int'(res) == prev, "R8 read while busy", int'(res), prev);
        if (poke && n == 5) acq = 1'b1;
        if (poke && n == 6) acq = 1'b0;
        if (poke && n == 7 && busy) chk(hold == 1'b1, "R9 acq during busy", int'(hold), 1);
      end
    end
    tick_mode = 0;
    chk(eoc == 1'b1, "R4 eoc", int'(eoc), 1);
    chk(busy == 1'b0, "R4 busy drop", int'(busy), 0);
    chk(tcnt - t0 == W * DIV, "R4 tick count", tcnt - t0, W * DIV);
    chk(int'(res) == exp_res(lv, b), b ? "R6 bipolar result" : "R5 unipolar result",
        int'(res), exp_res(lv, b));
    prev = exp_res(lv, b);
    @(negedge clk);
    chk(eoc == 1'b0, "R4 eoc one cycle", int'(eoc), 0);
  endtask

  initial begin
    int e0;
    void'($urandom(32'd5151));
    repeat (3) @(negedge clk);
    chk(!busy && !eoc && hold && dac == 0 && res == 0, "R1 reset state",
        int'({busy, eoc, hold}), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && hold && res == 0, "R1 after release", int'({busy, hold}), 1);

    // R9: stop while idle starts nothing
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk(!busy && hold, "R9 stop idle", int'({busy, hold}), 1);

    // directed corners, both codings
    run_conv(0, 1'b0, 0, 1'b0);
    run_conv(4095, 1'b0, 0, 1'b0);
    run_conv(2048, 1'b1, 0, 1'b0);
    run_conv(2047, 1'b1, 0, 1'b0);
    run_conv(0, 1'b1, 1, 1'b0);
    run_conv(4095, 1'b1, 1, 1'b1);

    // R7: abort during conversion
    level = 1234;
    @(negedge clk) acq = 1'b1;
    @(negedge clk) acq = 1'b0;
    @(negedge clk) stop = 1'b1; bip = 1'b0;
    @(negedge clk) stop = 1'b0; tick_mode = 1;
    repeat (10) @(negedge clk);
    e0 = ecnt;
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk(!busy && hold, "R7 abort conv", int'({busy, hold}), 1);
    repeat (60) @(negedge clk);
    tick_mode = 0;
    chk(ecnt == e0, "R7 no eoc after abort", ecnt, e0);
    chk(int'(res) == prev, "R7 result kept", int'(res), prev);

    // R7: abort during tracking
    @(negedge clk) acq = 1'b1;
    @(negedge clk) acq = 1'b0;
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk(hold == 1'b1 && !busy, "R7 abort track", int'(hold), 1);

    // random conversions
    for (int i = 0; i < 40; i++)
      run_conv($urandom_range(0, 4095), 1'($urandom_range(0, 1)), 1, 1'($urandom_range(0, 1)));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule